// File: doc/BRIEF.md
# Segmented Address Generator

This block turns a segment selector and an offset into a physical address. It supports a shift-and-add real mode and a descriptor-based protected mode, and it can hand the result to an external translation port. A selector either arrives directly with the request or is taken from one of four internal segment registers. Software loads these registers through a write port.

In real mode the base is the selector shifted left by four bit positions. The 20-bit sum with the low 16 offset bits is the final address, and it is ready one clock after the request. In protected mode the selector picks an entry in one of two small descriptor tables, global or local, which are also loaded through a write port. The 32-bit base from that entry plus the offset gives the linear address one clock later than in real mode.

When paging is enabled, a protected-mode linear address is sent out on a translation request strobe. It is not reported as a physical address. The controller has two states. ST_IDLE accepts a request: a real-mode request stays in ST_IDLE and produces its result, and a protected-mode request moves to ST_LOOKUP. ST_LOOKUP always returns to ST_IDLE after one cycle and emits either the done strobe or the translation strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, done and xlat_req are low, and phys_addr and xlat_addr are zero.
- R2: The selector is sel_value when sel_explicit is 1. Otherwise it is the segment register picked by seg_sel (0 = code, 1 = data, 2 = stack, 3 = extra). Segment register sreg_idx is loaded with sreg_wdata on a clock where sreg_we is 1.
- R3: A real-mode request (prot_mode = 0) accepted in ST_IDLE raises done in the next cycle. phys_addr then equals (selector × 16 + offset[15:0]) mod 2^20, and bits 31:20 are zero. Offset bits 31:16 are ignored.
- R4: In real mode, paging_en has no effect: done is raised and xlat_req stays low.
- R5: In protected mode, selector bit 2 picks the local table (1) or the global table (0), and selector bits 6:3 pick one of 16 entries. Selector bits 15:7 and 1:0 are ignored.
- R6: A protected-mode request produces no strobe in the cycle after acceptance. In the second cycle it gives (base + offset) mod 2^32.
- R7: In protected mode with paging_en = 1, the second cycle raises xlat_req with xlat_addr equal to the linear address. done stays low and phys_addr keeps its previous value.
- R8: A request presented while in ST_LOOKUP is ignored and produces no result.
- R9: done and xlat_req are never high in the same cycle.
- R10: A clock with desc_we = 1 writes desc_wdata into entry desc_idx of the local table (desc_local = 1) or the global table (desc_local = 0). Later lookups of that entry return the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Address request |
| sel_explicit | input | 1 | Use sel_value as the selector |
| sel_value | input | 16 | Explicit selector |
| seg_sel | input | 2 | Segment register choice |
| offset | input | 32 | Offset within the segment |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| paging_en | input | 1 | Send protected-mode linear addresses to translation |
| sreg_we | input | 1 | Segment register write enable |
| sreg_idx | input | 2 | Segment register to write |
| sreg_wdata | input | 16 | Segment register write value |
| desc_we | input | 1 | Descriptor write enable |
| desc_local | input | 1 | Write to the local table (1) or the global table (0) |
| desc_idx | input | 4 | Descriptor entry to write |
| desc_wdata | input | 32 | Descriptor base value |
| done | output | 1 | phys_addr is valid this cycle |
| phys_addr | output | 32 | Physical address |
| xlat_req | output | 1 | Translation request strobe |
| xlat_addr | output | 32 | Linear address sent for translation |

## Verification
Real-mode requests are tried through all four segment registers and through an explicit selector. This tells the register choice apart from the override. Selectors near the top of the range check the 1 MiB wrap, and offsets with set upper bits show that those bits are dropped.

Protected-mode lookups use the same entry number in both tables. This separates the table-select bit from the index. Selectors with set high and low bits confirm that only bits 6:3 index the table.

A base near 2^32 checks the 32-bit wrap. Rewriting a descriptor shows that later lookups follow the new contents.

Paging on, compared with paging off, tells the translation strobe from the done strobe in both modes. A request held through ST_LOOKUP separates a correctly ignored request from a spurious second result.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_LOOKUP = 1'b1
    } gen_state_t;

    localparam int REAL_SHIFT = 4;
    localparam int TI_BIT     = 2;
    localparam int IDX_LSB    = 3;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int SEL_W    = 16,
    parameter int NUM_SREG = 4,
    localparam int IDX_W   = $clog2(NUM_SREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [SEL_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [SEL_W-1:0] rdata
);
    logic [SEL_W-1:0] regs [NUM_SREG];

    for (genvar g = 0; g < NUM_SREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && widx == IDX_W'(g))
                regs[g] <= wdata;
        end
    end

    assign rdata = regs[ridx];
endmodule

// File: rtl/desc_table.sv
module desc_table #(
    parameter int BASE_W  = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wlocal,
    input  logic [IDX_W-1:0]  widx,
    input  logic [BASE_W-1:0] wdata,
    input  logic              re,
    input  logic              rlocal,
    input  logic [IDX_W-1:0]  ridx,
    output logic [BASE_W-1:0] rdata
);
    logic [BASE_W-1:0] mem [2*ENTRIES];

    always_ff @(posedge clk) begin
        if (we)
            mem[{wlocal, widx}] <= wdata;
        if (re)
            rdata <= mem[{rlocal, ridx}];
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_pkg::*;
#(
    parameter int SEL_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int NUM_SREG     = 4,
    parameter int DESC_ENTRIES = 16,
    localparam int SREG_IDX_W  = $clog2(NUM_SREG),
    localparam int DIDX_W      = $clog2(DESC_ENTRIES),
    localparam int REAL_W      = SEL_W + REAL_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic                  sel_explicit,
    input  logic [SEL_W-1:0]      sel_value,
    input  logic [SREG_IDX_W-1:0] seg_sel,
    input  logic [ADDR_W-1:0]     offset,
    input  logic                  prot_mode,
    input  logic                  paging_en,
    input  logic                  sreg_we,
    input  logic [SREG_IDX_W-1:0] sreg_idx,
    input  logic [SEL_W-1:0]      sreg_wdata,
    input  logic                  desc_we,
    input  logic                  desc_local,
    input  logic [DIDX_W-1:0]     desc_idx,
    input  logic [ADDR_W-1:0]     desc_wdata,
    output logic                  done,
    output logic [ADDR_W-1:0]     phys_addr,
    output logic                  xlat_req,
    output logic [ADDR_W-1:0]     xlat_addr
);
    gen_state_t        state, state_nx;
    logic [SEL_W-1:0]  sreg_val, sel_cur;
    logic [REAL_W-1:0] real_sum;
    logic [ADDR_W-1:0] desc_base, off_q, prot_sum;
    logic              pg_q, accept;

    seg_regfile #(.SEL_W(SEL_W), .NUM_SREG(NUM_SREG)) u_sregs (
        .clk(clk), .rst_n(rst_n), .we(sreg_we), .widx(sreg_idx),
        .wdata(sreg_wdata), .ridx(seg_sel), .rdata(sreg_val)
    );

    assign sel_cur = sel_explicit ? sel_value : sreg_val;
    assign accept  = req && (state == ST_IDLE);

    // real mode: shift-and-add, wraps within REAL_W bits
    assign real_sum = {sel_cur, {REAL_SHIFT{1'b0}}} + REAL_W'(offset[SEL_W-1:0]);

    desc_table #(.BASE_W(ADDR_W), .ENTRIES(DESC_ENTRIES)) u_desc (
        .clk(clk), .we(desc_we), .wlocal(desc_local), .widx(desc_idx),
        .wdata(desc_wdata), .re(accept && prot_mode),
        .rlocal(sel_cur[TI_BIT]), .ridx(sel_cur[IDX_LSB +: DIDX_W]),
        .rdata(desc_base)
    );

    assign prot_sum = desc_base + off_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            pg_q  <= 1'b0;
        end else if (accept && prot_mode) begin
            off_q <= offset;
            pg_q  <= paging_en;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept && prot_mode) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            xlat_req  <= 1'b0;
            phys_addr <= '0;
            xlat_addr <= '0;
        end else begin
            done     <= 1'b0;
            xlat_req <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept && !prot_mode) begin
                    done      <= 1'b1;
                    phys_addr <= ADDR_W'(real_sum);
                end
                ST_LOOKUP: if (pg_q) begin
                    xlat_req  <= 1'b1;
                    xlat_addr <= prot_sum;
                end else begin
                    done      <= 1'b1;
                    phys_addr <= prot_sum;
                end
            endcase
        end
    end

    assert_real_lat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !prot_mode) |=> (done && phys_addr[ADDR_W-1:REAL_W] == '0));
    assert_prot_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && prot_mode) |=> (!done && !xlat_req));
    assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && pg_q) |=> (xlat_req && !done && $stable(phys_addr)));
    assert_lookup_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP) |=> (state == ST_IDLE));
    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && xlat_req));
endmodule

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, sel_explicit, prot_mode, paging_en;
    logic [15:0] sel_value, sreg_wdata;
    logic [1:0]  seg_sel, sreg_idx;
    logic [31:0] offset, desc_wdata;
    logic        sreg_we, desc_we, desc_local;
    logic [3:0]  desc_idx;
    logic        done, xlat_req;
    logic [31:0] phys_addr, xlat_addr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .req(req), .sel_explicit(sel_explicit),
        .sel_value(sel_value), .seg_sel(seg_sel), .offset(offset),
        .prot_mode(prot_mode), .paging_en(paging_en), .sreg_we(sreg_we),
        .sreg_idx(sreg_idx), .sreg_wdata(sreg_wdata), .desc_we(desc_we),
        .desc_local(desc_local), .desc_idx(desc_idx), .desc_wdata(desc_wdata),
        .done(done), .phys_addr(phys_addr), .xlat_req(xlat_req),
        .xlat_addr(xlat_addr)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] real_exp(logic [15:0] s, logic [31:0] o);
        logic [19:0] sum;
        sum = {s, 4'b0} + {4'b0, o[15:0]};
        return {12'b0, sum};
    endfunction

    task automatic wr_sreg(logic [1:0] i, logic [15:0] v);
        sreg_we = 1'b1; sreg_idx = i; sreg_wdata = v;
        @(negedge clk);
        sreg_we = 1'b0;
    endtask

    task automatic wr_desc(logic loc, logic [3:0] i, logic [31:0] v);
        desc_we = 1'b1; desc_local = loc; desc_idx = i; desc_wdata = v;
        @(negedge clk);
        desc_we = 1'b0;
    endtask

    // presents a request for one cycle; returns at the negedge after acceptance
    task automatic issue(logic ex, logic [15:0] sv, logic [1:0] ss,
                         logic [31:0] off, logic pm, logic pg);
        req = 1'b1; sel_explicit = ex; sel_value = sv; seg_sel = ss;
        offset = off; prot_mode = pm; paging_en = pg;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 xlat_req", {31'b0, xlat_req}, 32'd0);
        chk("R1 phys_addr", phys_addr, 32'd0);
        chk("R1 xlat_addr", xlat_addr, 32'd0);
    endtask

    task automatic t_real_sregs;
        logic [15:0] vals [4] = '{16'h1234, 16'h2000, 16'hFFFF, 16'h0800};
        logic [31:0] offs [4] = '{32'h0000_0010, 32'h0000_1234, 32'h0000_0020, 32'hABCD_0005};
        for (int i = 0; i < 4; i++) wr_sreg(2'(i), vals[i]);
        for (int i = 0; i < 4; i++) begin
            issue(1'b0, 16'h0, 2'(i), offs[i], 1'b0, 1'b0);
            chk("R2 R3 done", {31'b0, done}, 32'd1);
            chk("R2 R3 phys", phys_addr, real_exp(vals[i], offs[i]));
        end
        issue(1'b1, 16'h0001, 2'd0, 32'h0, 1'b0, 1'b0);
        chk("R2 explicit phys", phys_addr, 32'h0000_0010);
        issue(1'b1, 16'hFFFF, 2'd0, 32'h0000_0010, 1'b0, 1'b0);
        chk("R3 wrap phys", phys_addr, 32'h0000_0000);
    endtask

    task automatic t_real_paging;
        issue(1'b1, 16'h0100, 2'd0, 32'h1, 1'b0, 1'b1);
        chk("R4 done", {31'b0, done}, 32'd1);
        chk("R4 xlat_req", {31'b0, xlat_req}, 32'd0);
        chk("R4 phys", phys_addr, 32'h0000_1001);
    endtask

    task automatic prot_check(string tag, logic [15:0] sv, logic [31:0] off, logic [31:0] exp);
        issue(1'b1, sv, 2'd0, off, 1'b1, 1'b0);
        chk({tag, " R6 no early done"}, {31'b0, done}, 32'd0);
        @(negedge clk);
        chk({tag, " done"}, {31'b0, done}, 32'd1);
        chk({tag, " phys"}, phys_addr, exp);
        chk({tag, " R9 excl"}, {31'b0, done & xlat_req}, 32'd0);
    endtask

    task automatic t_protected;
        wr_desc(1'b0, 4'd3, 32'h1234_0000);
        wr_desc(1'b1, 4'd3, 32'h5678_0000);
        wr_desc(1'b0, 4'd5, 32'hFFFF_FFF0);
        prot_check("R5 global", 16'h0018, 32'h100, 32'h1234_0100);
        prot_check("R5 local", 16'h001F, 32'h100, 32'h5678_0100);
        prot_check("R5 high bits", 16'hFF18, 32'h100, 32'h1234_0100);
        prot_check("R6 wrap", 16'h0028, 32'h20, 32'h0000_0010);
        wr_desc(1'b0, 4'd3, 32'hA000_0000);
        prot_check("R10 rewrite", 16'h0018, 32'h4, 32'hA000_0004);
    endtask

    task automatic t_paging;
        issue(1'b1, 16'h0018, 2'd0, 32'h8, 1'b1, 1'b1);
        chk("R7 no early xlat", {31'b0, xlat_req}, 32'd0);
        @(negedge clk);
        chk("R7 xlat_req", {31'b0, xlat_req}, 32'd1);
        chk("R7 xlat_addr", xlat_addr, 32'hA000_0008);
        chk("R7 done low", {31'b0, done}, 32'd0);
        chk("R7 phys kept", phys_addr, 32'hA000_0004);
    endtask

    task automatic t_busy;
        issue(1'b1, 16'h0018, 2'd0, 32'h40, 1'b1, 1'b0);
        req = 1'b1; sel_explicit = 1'b1; sel_value = 16'h0200;
        offset = 32'h0; prot_mode = 1'b0; paging_en = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk("R8 first result", phys_addr, 32'hA000_0040);
        @(negedge clk);
        chk("R8 ignored done", {31'b0, done}, 32'd0);
        chk("R8 ignored phys", phys_addr, 32'hA000_0040);
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = 1'b0; sel_explicit = 1'b0; sel_value = '0;
        seg_sel = '0; offset = '0; prot_mode = 1'b0; paging_en = 1'b0;
        sreg_we = 1'b0; sreg_idx = '0; sreg_wdata = '0;
        desc_we = 1'b0; desc_local = 1'b0; desc_idx = '0; desc_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_real_sregs();
        t_real_paging();
        t_protected();
        t_paging();
        t_busy();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule